// File: doc/BRIEF.md
# Cascadable Column Data Loader

This block collects gray-scale pixel codes for one column driver of a flat panel and holds them for conversion. Each clock it accepts three 6-bit dots and writes them into a group of three neighbouring channels, walking a group pointer across the channel row. The walk starts when a start pulse is seen on the start pin that currently has the input role. When the last group of the row has been written, the block raises a one-clock pulse on the opposite start pin, and that pulse starts the next driver in a chain.

The walk can run upward, from channel 1 to the top channel, or downward. A direction input decides which start pin takes input and which one drives the cascade pulse. Each pin has its own output-enable. A narrow mode uses 300 of the 309 channels. In that mode the pointer steps over the middle band of channels 151 to 159 without spending a clock, so the cascade pulse comes after 100 loads instead of 103. An invert input stores the bitwise complement of each dot as it is written.

A rising edge on the strobe input copies the data register into the output latch, whose contents are the block's output, and returns the pointer to idle. Loading is disabled after reset until the first strobe edge has been seen.

Top module: `column_loader`

## Requirements
- R1: On each load edge, the dot in `dots_i[6j+5:6j]` (j = 0, 1, 2) is written to channel 3g+1+j of the group g being loaded. Channel c (1-based) of the output appears on `codes_o[6(c-1)+5 : 6(c-1)]`, with bit 0 as the LSB.
- R2: When `invert` is 1, the bitwise complement of each dot is stored. When it is 0, the dot is stored unchanged.
- R3: Reset clears every latched code to 0. Until the first strobe rising edge, start pulses and clocks load nothing and produce no cascade pulse.
- R4: With `scan_up`=1, `start_r_i` is the start input, groups are written from channel 1 upward, `start_l_oe`=1 and `start_r_oe`=0. With `scan_up`=0, `start_l_i` is the start input, groups are written from channel 309 downward, and the enables are swapped.
- R5: With `narrow_mode`=1, channels 151..159 are never written and keep their earlier contents. The pointer passes straight from the group that holds 148..150 to the group that holds 160..162, or the reverse when scanning down.
- R6: The edge that sees the start pulse loads the first group. The cascade pulse is high for exactly the one cycle that follows the edge loading the 103rd group (100th in narrow mode). It appears on `start_l_o` when scanning up and on `start_r_o` when scanning down. The start pin in the input role is driven 0.
- R7: `codes_o` changes only on the clock after a strobe rising edge. At that point it takes the data register contents as they stood before that edge.
- R8: After the final group of a row has been loaded, further clocks change no stored data until the next strobe.
- R9: A start pulse that arrives while a row is loading restarts the row at its first group. The cascade pulse is then timed from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_up | input | 1 | 1: load channel 1 upward, 0: load channel 309 downward |
| narrow_mode | input | 1 | 1: 300 active channels, 0: 309 active channels |
| invert | input | 1 | 1: store complemented dots |
| dots_i | input | 18 | Three 6-bit dots for one group |
| strobe | input | 1 | Rising edge latches the data register and idles the pointer |
| start_r_i | input | 1 | Right start pin, input side |
| start_l_i | input | 1 | Left start pin, input side |
| start_r_o | output | 1 | Right start pin, cascade drive |
| start_r_oe | output | 1 | Right start pin output enable |
| start_l_o | output | 1 | Left start pin, cascade drive |
| start_l_oe | output | 1 | Left start pin output enable |
| codes_o | output | 1854 | Latched 6-bit codes, channel 1 in the low bits |

## Verification
The hardest case to reach from the ports is the narrow-mode hop over the middle band, in particular checking that channels 151..159 keep old data rather than reading zero by chance. The stimulus therefore always runs a full 309-channel row with distinctive values first. A 300-channel row then follows in the same direction, and the bench expects the old band values to survive the strobe. Restart is reached by cutting a row short with a second start pulse after twenty groups. The cascade pulse must then follow the second pulse by the full count.

// File: rtl/coldl_pkg.sv
package coldl_pkg;

    localparam int DOT_BITS = 6;
    localparam int DOTS_PER_LOAD = 3;

    typedef enum logic {
        SCAN_DOWN = 1'b0,
        SCAN_UP   = 1'b1
    } scan_dir_e;

endpackage

// File: rtl/coldl_seq.sv
module coldl_seq
    import coldl_pkg::*;
#(
    parameter int NUM_GRP = 103,
    parameter int GAP_G0  = 50,
    parameter int GAP_G1  = 52,
    parameter int GW      = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  scan_dir_e     dir,
    input  logic          narrow,
    input  logic          start_in,
    input  logic          strobe,
    output logic          wr_en,
    output logic [GW-1:0] wr_grp,
    output logic          latch_en,
    output logic          casc
);

    localparam int GAP_N = GAP_G1 - GAP_G0 + 1;
    localparam logic [GW-1:0] LAST_G   = GW'(NUM_GRP - 1);
    localparam logic [GW-1:0] BELOW_G  = GW'(GAP_G0 - 1);
    localparam logic [GW-1:0] ABOVE_G  = GW'(GAP_G1 + 1);
    localparam logic [GW-1:0] FULL_N   = GW'(NUM_GRP);
    localparam logic [GW-1:0] SKIP_N   = GW'(NUM_GRP - GAP_N);

    typedef struct packed {
        logic          armed;
        logic          active;
        logic          strb;
        logic          casc;
        logic [GW-1:0] grp;
        logic [GW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic [GW-1:0] nxt_grp_d, nxt_cnt_d, target_d, step_d;
    logic          load_d;

    always_comb begin
        if (dir == SCAN_UP) begin
            step_d = (narrow && s_q.grp == BELOW_G) ? ABOVE_G : s_q.grp + 1'b1;
        end else begin
            step_d = (narrow && s_q.grp == ABOVE_G) ? BELOW_G : s_q.grp - 1'b1;
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.casc  = 1'b0;
        s_d.strb  = strobe;
        load_d    = 1'b0;
        nxt_grp_d = step_d;
        nxt_cnt_d = s_q.cnt + 1'b1;
        target_d  = narrow ? SKIP_N : FULL_N;
        latch_en  = strobe && !s_q.strb;
        if (latch_en) begin
            s_d.armed  = 1'b1;
            s_d.active = 1'b0;
            s_d.grp    = '0;
            s_d.cnt    = '0;
        end else if (s_q.armed && start_in) begin
            load_d    = 1'b1;
            nxt_grp_d = (dir == SCAN_UP) ? '0 : LAST_G;
            nxt_cnt_d = GW'(1);
        end else if (s_q.armed && s_q.active) begin
            load_d = 1'b1;
        end
        if (load_d) begin
            s_d.grp    = nxt_grp_d;
            s_d.cnt    = nxt_cnt_d;
            s_d.active = (nxt_cnt_d != target_d);
            s_d.casc   = (nxt_cnt_d == target_d);
        end
        wr_en  = load_d;
        wr_grp = nxt_grp_d;
        casc   = s_q.casc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: no load before the first strobe edge
    a_r3_idle_until_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.armed && !latch_en) |-> !wr_en);

    // R6: cascade pulse lasts a single cycle
    a_r6_casc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        casc |=> !casc);

    // R6: cascade only follows a load edge
    a_r6_casc_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        casc |-> $past(wr_en));

endmodule

// File: rtl/coldl_rows.sv
module coldl_rows #(
    parameter int NUM_GRP = 103,
    parameter int ROW_W   = 18,
    parameter int GW      = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [GW-1:0]            wr_grp,
    input  logic [ROW_W-1:0]         wr_row,
    output logic [NUM_GRP*ROW_W-1:0] rows_o
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_row
        logic [ROW_W-1:0] row_d, row_q;

        always_comb begin
            row_d = (wr_en && wr_grp == GW'(g)) ? wr_row : row_q;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else begin
                row_q <= row_d;
            end
        end

        assign rows_o[g*ROW_W +: ROW_W] = row_q;
    end

endmodule

// File: rtl/column_loader.sv
module column_loader
    import coldl_pkg::*;
#(
    parameter int NUM_CH    = 309,
    parameter int DOT_W     = DOT_BITS,
    parameter int DOTS      = DOTS_PER_LOAD,
    parameter int GAP_FIRST = 151,
    parameter int GAP_LAST  = 159
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_up,
    input  logic                    narrow_mode,
    input  logic                    invert,
    input  logic [DOTS*DOT_W-1:0]   dots_i,
    input  logic                    strobe,
    input  logic                    start_r_i,
    input  logic                    start_l_i,
    output logic                    start_r_o,
    output logic                    start_r_oe,
    output logic                    start_l_o,
    output logic                    start_l_oe,
    output logic [NUM_CH*DOT_W-1:0] codes_o
);

    localparam int NUM_GRP = NUM_CH / DOTS;
    localparam int ROW_W   = DOTS * DOT_W;
    localparam int CODE_W  = NUM_GRP * ROW_W;
    localparam int GW      = $clog2(NUM_GRP + 1);
    localparam int G0      = (GAP_FIRST - 1) / DOTS;
    localparam int G1      = (GAP_LAST - 1) / DOTS;
    localparam logic [GW-1:0] G0_V = GW'(G0);
    localparam logic [GW-1:0] G1_V = GW'(G1);

    scan_dir_e           dir;
    logic                start_in, wr_en, latch_en, casc;
    logic [GW-1:0]       wr_grp;
    logic [ROW_W-1:0]    row_in;
    logic [CODE_W-1:0]   rows, codes_d, codes_q;

    always_comb begin
        dir        = scan_up ? SCAN_UP : SCAN_DOWN;
        start_in   = scan_up ? start_r_i : start_l_i;
        row_in     = invert ? ~dots_i : dots_i;
        start_l_oe = scan_up;
        start_r_oe = !scan_up;
        start_l_o  = scan_up && casc;
        start_r_o  = !scan_up && casc;
        codes_d    = latch_en ? rows : codes_q;
    end

    coldl_seq #(
        .NUM_GRP (NUM_GRP),
        .GAP_G0  (G0),
        .GAP_G1  (G1),
        .GW      (GW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir      (dir),
        .narrow   (narrow_mode),
        .start_in (start_in),
        .strobe   (strobe),
        .wr_en    (wr_en),
        .wr_grp   (wr_grp),
        .latch_en (latch_en),
        .casc     (casc)
    );

    coldl_rows #(
        .NUM_GRP (NUM_GRP),
        .ROW_W   (ROW_W),
        .GW      (GW)
    ) u_rows (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_grp (wr_grp),
        .wr_row (row_in),
        .rows_o (rows)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            codes_q <= '0;
        end else begin
            codes_q <= codes_d;
        end
    end

    assign codes_o = codes_q;

    // R5: narrow mode never writes the middle band
    a_r5_band_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_mode && wr_en) |-> (wr_grp < G0_V || wr_grp > G1_V));

    // R7: output latch moves only after a strobe edge
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(codes_o));

endmodule

// File: tb/column_loader_tb.sv
module column_loader_tb;

    localparam int NCH  = 309;
    localparam int NGRP = 103;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scan_up = 1'b1, narrow_mode = 1'b0, invert = 1'b0;
    logic [17:0]       dots_i = '0;
    logic              strobe = 1'b0, start_r_i = 1'b0, start_l_i = 1'b0;
    logic              start_r_o, start_r_oe, start_l_o, start_l_oe;
    logic [NCH*6-1:0]  codes_o;

    logic [5:0] exp_dat [NCH];
    logic [5:0] exp_lat [NCH];
    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    column_loader u_dut (
        .clk(clk), .rst_n(rst_n), .scan_up(scan_up), .narrow_mode(narrow_mode),
        .invert(invert), .dots_i(dots_i), .strobe(strobe),
        .start_r_i(start_r_i), .start_l_i(start_l_i),
        .start_r_o(start_r_o), .start_r_oe(start_r_oe),
        .start_l_o(start_l_o), .start_l_oe(start_l_oe), .codes_o(codes_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_latch(input string req);
        for (int c = 0; c < NCH; c++) begin
            chk((c >= 150 && c <= 158) ? "R5" : req, 32'(codes_o[c*6 +: 6]), 32'(exp_lat[c]));
        end
    endtask

    task automatic check_pins(input bit dir, input bit casc_exp, input string req);
        chk(req, 32'(dir ? start_l_o : start_r_o), 32'(casc_exp));
        chk("R6", 32'(dir ? start_r_o : start_l_o), 32'd0);
        chk("R4", 32'(start_l_oe), 32'(dir));
        chk("R4", 32'(start_r_oe), 32'(!dir));
    endtask

    // group index loaded on the k-th load edge after a start (k from 0)
    function automatic int grp_of(input bit dir, input bit md, input int k);
        int lin;
        lin = (md && k >= 50) ? k + 3 : k;
        return dir ? lin : (NGRP - 1) - lin;
    endfunction

    task automatic drive_start(input bit dir, input bit v);
        start_r_i = dir ? v : 1'b0;
        start_l_i = dir ? 1'b0 : v;
    endtask

    task automatic strobe_and_check(input string req);
        @(negedge clk);
        drive_start(scan_up, 1'b0);
        check_latch("R7");
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        for (int c = 0; c < NCH; c++) exp_lat[c] = exp_dat[c];
        check_latch(req);
    endtask

    task automatic run_frame(input int fr, input bit dir, input bit md, input bit inv,
                             input int pre, input string ctag);
        int total;
        total = md ? 100 : 103;
        @(negedge clk);
        scan_up = dir; narrow_mode = md; invert = inv;
        drive_start(dir, 1'b0);
        for (int k = 0; k < pre; k++) begin
            @(negedge clk);
            if (k > 0) check_pins(dir, 1'b0, "R9");
            drive_start(dir, k == 0);
            dots_i = 18'(k * 4099 + 77);
        end
        for (int k = 0; k < total + 4; k++) begin
            @(negedge clk);
            if (k > 0 || pre > 0) check_pins(dir, k == total, ctag);
            drive_start(dir, k == 0);
            if (k < total) begin
                for (int j = 0; j < 3; j++) begin
                    logic [5:0] v;
                    v = 6'((fr * 13 + k * 7 + j * 19 + 5) % 64);
                    dots_i[j*6 +: 6] = v;
                    exp_dat[grp_of(dir, md, k) * 3 + j] = inv ? ~v : v;
                end
            end else begin
                dots_i = 18'h2A5A5; // R8: must be ignored
            end
        end
        strobe_and_check(inv ? "R2" : "R1");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            exp_dat[c] = '0;
            exp_lat[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_latch("R3");
        check_pins(1'b1, 1'b0, "R3");
        // R3: loading disabled before first strobe
        for (int k = 0; k < 110; k++) begin
            drive_start(1'b1, k == 0);
            dots_i = 18'h3FFFF;
            @(negedge clk);
            check_pins(1'b1, 1'b0, "R3");
        end
        strobe_and_check("R3");
        // sweep direction, mode and polarity; 309 before 300 per direction
        for (int d = 1; d >= 0; d--) begin
            for (int m = 0; m < 2; m++) begin
                for (int i = 0; i < 2; i++) begin
                    run_frame(d * 4 + m * 2 + i, d[0], m[0], i[0], 0, d[0] ? "R6" : "R4");
                end
            end
        end
        // R9: restart part way through a row
        run_frame(9, 1'b1, 1'b0, 1'b0, 20, "R9");
        run_frame(10, 1'b0, 1'b1, 1'b1, 35, "R9");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule